// File: doc/BRIEF.md
# Serial DMA Request Encoder and Grant Decoder

This block is the peripheral-side agent of a serial DMA request/grant scheme. Seven parallel DMA request inputs cover channels 0 to 3 and 5 to 7. The block passes them through a two-stage synchronizer. It then reports the set of requesting channels to a central DMA controller as a serial frame on an active-low request line. Channel 4 has no input, and its slot always reads as idle.

The controller answers on a separate active-low grant line. It sends a start bit and then a three-bit channel number, least significant bit first. The block decodes this number and raises a one-clock valid strobe.

The request frame is sent again whenever the synchronized request set differs from the last frame sent. A pulse on the transfer-done input also forces a new frame while requests remain. Before each re-sent frame the line rests high for one clock after a set change, or two clocks after a completed transfer. The grant decoder is independent of the request encoder and can receive a grant while a request frame is still being sent.

Top module: `dma_ser_agent`

## Requirements
- R1: With no request active, the request line stays high. The start bit of a frame appears three clocks after the first request input rises from an idle state, counting the two synchronizer stages.
- R2: A request frame is a low start bit followed by eight one-clock slots for channels 0 to 7 in ascending order. A slot is low when its channel is requesting and high when it is not. Request inputs bits 3:0 map to channels 3:0, and bits 6:4 map to channels 7:5.
- R3: The slot of channel 4 is always high.
- R4: If the request set is unchanged after a frame and no transfer completes, no further frame is sent and the line stays high.
- R5: If the request set changes during a frame, that frame completes with the set captured at its start bit. The line is then high for exactly one clock, and a new frame carries the current set.
- R6: If the request set changes while the block waits after a frame, the new frame's start bit appears four clocks after the input change. This covers two synchronizer clocks, one decision clock and one high clock.
- R7: A transfer-done pulse while requests remain causes exactly two high clocks and then a re-sent frame, even with an unchanged set. If the pulse arrives during a frame, the two high clocks follow the end of that frame. If it arrives while waiting, they follow the clock that sampled it.
- R8: When every request drops after a frame, the line stays high and no frame is sent.
- R9: A grant frame is a low start bit followed by three channel bits, least significant bit first, taken at line level. The valid strobe is high for exactly one clock, in the clock after the last bit. The channel output holds the decoded number until the next grant.
- R10: A grant received during a request frame is decoded correctly and does not disturb the request frame.
- R11: During and just after reset, the request line is high, the valid strobe is low and the channel output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | 7 | Asynchronous DMA requests: bits 3:0 are channels 3:0, bits 6:4 are channels 7:5 |
| done_i | input | 1 | One-clock pulse when a granted transfer has finished |
| gnt_ni | input | 1 | Serial grant line from the controller, active low start bit |
| req_no | output | 1 | Serial request line to the controller, active low |
| gnt_ch_o | output | 3 | Last decoded grant channel |
| gnt_vld_o | output | 1 | One-clock strobe when a grant channel has been decoded |

## Verification
The hardest cases to reach are the ones where a set change or a transfer-done pulse coincides with a frame already on the line. The stimulus has to land on a chosen slot so that the captured set, the deferred re-send and the gap length can be told apart. The bench builds frames whose start times are known exactly from the synchronizer latency. It injects the input change or the done pulse at a fixed slot index, then checks the old frame, the exact number of high clocks and the new frame. A grant is driven in parallel with a request frame to show that the two serial paths run independently.

// File: rtl/dma_ser_pkg.sv
package dma_ser_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SEND,
    TX_HOLD,
    TX_GAP
  } tx_state_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dreq_frame_tx.sv
module dreq_frame_tx
  import dma_ser_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int GAP_CHG  = 1,
  parameter int GAP_DONE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_set_i,
  input  logic              done_i,
  output logic              req_no
);
  localparam int CNT_W = $clog2(NUM_CH + 1);
  localparam int GAP_MAX = (GAP_CHG > GAP_DONE) ? GAP_CHG : GAP_DONE;
  localparam int GAP_W = $clog2(GAP_MAX + 1);

  tx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NUM_CH-1:0] sent_q;
  logic [GAP_W-1:0]  gap_q;
  logic              done_pend_q;
  logic              last_slot, changed, any_req;
  logic [NUM_CH:0]   frame_bits;

  assign last_slot  = (cnt_q == CNT_W'(NUM_CH));
  assign changed    = (req_set_i != sent_q);
  assign any_req    = |req_set_i;
  assign frame_bits = {~sent_q, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= TX_IDLE;
      cnt_q       <= '0;
      sent_q      <= '0;
      gap_q       <= '0;
      done_pend_q <= 1'b0;
    end else begin
      case (st_q)
        TX_IDLE: if (any_req) begin
          st_q   <= TX_SEND;
          cnt_q  <= '0;
          sent_q <= req_set_i;
        end
        TX_SEND: begin
          if (done_i) done_pend_q <= 1'b1;
          if (!last_slot) cnt_q <= cnt_q + 1'b1;
          else begin
            done_pend_q <= 1'b0;
            if (!any_req) st_q <= TX_IDLE;
            else if (done_pend_q || done_i) begin
              st_q  <= TX_GAP;
              gap_q <= GAP_W'(GAP_DONE);
            end else if (changed) begin
              st_q  <= TX_GAP;
              gap_q <= GAP_W'(GAP_CHG);
            end else st_q <= TX_HOLD;
          end
        end
        TX_HOLD: begin
          if (!any_req) st_q <= TX_IDLE;
          else if (done_i) begin
            st_q  <= TX_GAP;
            gap_q <= GAP_W'(GAP_DONE);
          end else if (changed) begin
            st_q  <= TX_GAP;
            gap_q <= GAP_W'(GAP_CHG);
          end
        end
        TX_GAP: begin
          if (gap_q == GAP_W'(1)) begin
            if (any_req) begin
              st_q   <= TX_SEND;
              cnt_q  <= '0;
              sent_q <= req_set_i;
            end else st_q <= TX_IDLE;
          end else gap_q <= gap_q - 1'b1;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  // line idles high; start bit at slot 0, channels after it
  always_comb begin
    req_no = 1'b1;
    if (st_q == TX_SEND) req_no = frame_bits[cnt_q];
  end
endmodule

// File: rtl/dgnt_frame_rx.sv
module dgnt_frame_rx #(
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            gnt_ni,
  output logic [CH_W-1:0] ch_o,
  output logic            vld_o
);
  localparam int BC_W = (CH_W > 2) ? $clog2(CH_W) : 1;

  logic            busy_q;
  logic [BC_W-1:0] bit_q;
  logic [CH_W-1:0] sh_q;
  logic [CH_W-1:0] sh_d;

  // LSB arrives first: shift in at the top
  assign sh_d = {gnt_ni, sh_q[CH_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      ch_o   <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!busy_q) begin
        if (!gnt_ni) begin
          busy_q <= 1'b1;
          bit_q  <= '0;
        end
      end else begin
        sh_q <= sh_d;
        if (bit_q == BC_W'(CH_W - 1)) begin
          busy_q <= 1'b0;
          vld_o  <= 1'b1;
          ch_o   <= sh_d;
        end else bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_ser_agent.sv
module dma_ser_agent #(
  parameter int NUM_CH   = 8,
  parameter int SKIP_CH  = 4,
  parameter int SYNC_STG = 2,
  parameter int GAP_CHG  = 1,
  parameter int GAP_DONE = 2,
  localparam int IN_W    = NUM_CH - 1,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] dreq_i,
  input  logic            done_i,
  input  logic            gnt_ni,
  output logic            req_no,
  output logic [CH_W-1:0] gnt_ch_o,
  output logic            gnt_vld_o
);
  logic [IN_W-1:0]   dreq_s;
  logic [NUM_CH-1:0] req_set;

  dreq_sync #(.W(IN_W), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dreq_i),
    .q_o   (dreq_s)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    if (c < SKIP_CH) begin : g_lo
      assign req_set[c] = dreq_s[c];
    end else if (c == SKIP_CH) begin : g_skip
      assign req_set[c] = 1'b0;
    end else begin : g_hi
      assign req_set[c] = dreq_s[c-1];
    end
  end

  dreq_frame_tx #(.NUM_CH(NUM_CH), .GAP_CHG(GAP_CHG), .GAP_DONE(GAP_DONE)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_set_i(req_set),
    .done_i   (done_i),
    .req_no   (req_no)
  );

  dgnt_frame_rx #(.CH_W(CH_W)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gnt_ni(gnt_ni),
    .ch_o  (gnt_ch_o),
    .vld_o (gnt_vld_o)
  );
endmodule

// File: rtl/dma_ser_agent_chk.sv
module dma_ser_agent_chk #(
  parameter int NUM_CH  = 8,
  parameter int SKIP_CH = 4,
  parameter int CH_W    = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_no,
  input logic            gnt_ni,
  input logic            gnt_vld_o,
  input logic [CH_W-1:0] gnt_ch_o
);
  localparam int POS_W = $clog2(NUM_CH + 1);

  logic [POS_W-1:0] pos_q;
  logic [CH_W:0]    hist_q;

  // independent frame tracker from the serial line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      hist_q <= '1;
    end else begin
      hist_q <= {gnt_ni, hist_q[CH_W:1]};
      if (pos_q == '0) begin
        if (!req_no) pos_q <= POS_W'(1);
      end else if (pos_q == POS_W'(NUM_CH)) pos_q <= '0;
      else pos_q <= pos_q + 1'b1;
    end
  end

  p_ch4_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_W'(SKIP_CH + 1)) |-> req_no);

  p_gap_after_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == POS_W'(NUM_CH)) |=> req_no);

  p_vld_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |=> !gnt_vld_o);

  p_gnt_decode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> (!hist_q[0] && gnt_ch_o == hist_q[CH_W:1]));

  p_ch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_vld_o |=> (gnt_vld_o || $stable(gnt_ch_o)));
endmodule

bind dma_ser_agent dma_ser_agent_chk #(.NUM_CH(NUM_CH), .SKIP_CH(SKIP_CH), .CH_W(CH_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_no   (req_no),
  .gnt_ni   (gnt_ni),
  .gnt_vld_o(gnt_vld_o),
  .gnt_ch_o (gnt_ch_o)
);

// File: tb/tb_dma_ser_agent.sv
`timescale 1ns/1ps
module tb_dma_ser_agent;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [6:0] dreq;
  logic       done;
  logic       gnt_n;
  logic       req_n;
  logic [2:0] gnt_ch;
  logic       gnt_vld;
  int         n_chk = 0;
  int         n_bad = 0;

  localparam logic [6:0] VEC [6] = '{7'b0000001, 7'b1000000, 7'b0101010,
                                     7'b1111111, 7'b0010100, 7'b1010011};

  always #4 clk = ~clk;

  dma_ser_agent dut (
    .clk_i(clk), .rst_ni(rst_ni), .dreq_i(dreq), .done_i(done),
    .gnt_ni(gnt_n), .req_no(req_n), .gnt_ch_o(gnt_ch), .gnt_vld_o(gnt_vld)
  );

  function automatic logic [7:0] expand(input logic [6:0] p);
    return {p[6:4], 1'b0, p[3:0]};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic high(input int k, input string tag);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk({7'd0, req_n}, 8'd1, tag);
    end
  endtask

  // start bit at next negedge, then eight slots; optional done / input change at a slot
  task automatic frame(input logic [7:0] exp, input int done_at, input int chg_at,
                       input logic [6:0] chg_val);
    @(negedge clk);
    chk({7'd0, req_n}, 8'd0, "R2 start");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk({7'd0, req_n}, {7'd0, ~exp[i]}, (i == 4) ? "R3 slot" : "R2 slot");
      done = (i == done_at);
      if (i == chg_at) dreq = chg_val;
    end
    done = 1'b0;
  endtask

  task automatic grant(input logic [2:0] ch, input string tag);
    @(negedge clk) gnt_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) gnt_n = ch[i];
    end
    @(negedge clk) gnt_n = 1'b1;
    chk({7'd0, gnt_vld}, 8'd1, tag);
    chk({5'd0, gnt_ch}, {5'd0, ch}, tag);
    @(negedge clk);
    chk({7'd0, gnt_vld}, 8'd0, tag);
    chk({5'd0, gnt_ch}, {5'd0, ch}, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; dreq = '0; done = 1'b0; gnt_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({7'd0, req_n}, 8'd1, "R11 req");
    chk({7'd0, gnt_vld}, 8'd0, "R11 vld");
    chk({5'd0, gnt_ch}, 8'd0, "R11 ch");
    rst_ni = 1'b1;
    @(negedge clk);
    chk({7'd0, req_n}, 8'd1, "R11 after");

    // table walk: idle start latency, frame, no re-send, drop to idle
    foreach (VEC[v]) begin
      dreq = VEC[v];
      high(2, "R1 latency");
      frame(expand(VEC[v]), -1, -1, '0);
      high(3, "R4 no resend");
      dreq = '0;
      high(12, "R8 all dropped");
    end

    // change while waiting
    dreq = 7'b0000001;
    high(2, "R1 latency");
    frame(expand(7'b0000001), -1, -1, '0);
    high(2, "R4 wait");
    dreq = 7'b0000011;
    high(3, "R6 gap");
    frame(expand(7'b0000011), -1, -1, '0);

    // drop during frame, after a change while waiting
    high(1, "R4 wait");
    dreq = 7'b0000111;
    high(3, "R6 gap");
    frame(expand(7'b0000111), -1, 1, 7'b0000101);
    high(1, "R5 one gap");
    frame(expand(7'b0000101), -1, -1, '0);

    // done while waiting, then done during frame
    high(1, "R4 wait");
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk({7'd0, req_n}, 8'd1, "R7 gap1");
    high(1, "R7 gap2");
    frame(expand(7'b0000101), 1, -1, '0);
    high(2, "R7 two gap");
    frame(expand(7'b0000101), -1, -1, '0);

    // add during frame with a concurrent grant
    high(1, "R4 wait");
    dreq = 7'b0010101;
    high(3, "R6 gap");
    fork
      frame(expand(7'b0010101), -1, 3, 7'b1010101);
      grant(3'd6, "R10 concurrent");
    join
    high(1, "R5 one gap");
    frame(expand(7'b1010101), -1, -1, '0);

    // standalone grants
    grant(3'd1, "R9 ch1");
    grant(3'd7, "R9 ch7");
    grant(3'd0, "R9 ch0");
    dreq = '0;
    high(12, "R8 final idle");

    summary();
    $finish;
  end
endmodule